// File: doc/BRIEF.md
# Serial Channel Diagnostic Mode Router

This block stands between a serial channel's character transmitter and receiver and the channel's external pins: transmit data, receive data, request-to-send, clear-to-send and carrier detect. A two-bit diagnostic mode selects how serial bits travel between the internal shifters and the pins. In normal operation the transmitter drives the pin and the receiver listens to the pin. In local loopback the transmitter feeds the receiver directly. In automatic echo every received bit is sent straight back out. The fourth mode runs loopback and echo together.

Bit timing comes from two strobes, one for transmit and one for receive, both in the system clock domain. The mode decides which strobe times the receiver and which modem lines are honoured. A receive enable holds the receiver idle and empties the receive FIFO while it is low. Characters use a simple stand-in frame, and the bench uses the same frame. The active mode is reported on an output. A new mode is adopted only when both shifters are idle.

Top module: `diag_router`

## Requirements
- R1: `mode_req` is coded 00 normal, 01 local loopback, 10 automatic echo, 11 loopback plus echo. `mode_now` reports the active mode and is 00 after reset.
- R2: `mode_now` takes the value of `mode_req` one clock after a cycle in which both transmitter and receiver are idle. While either of them is busy, `mode_now` holds its value.
- R3: The frame is: line idle high, one start bit 0, DATA_W data bits LSB first, one stop bit 1. The transmitter sends one frame bit per `tx_tick`, and `txd_pin` shows the new bit one clock after the strobe.
- R4: In normal mode, `tx_ready` stays low and no character is accepted while `cts_pin` is low. The receiver begins a character only if `cd_pin` is high when it samples the start bit.
- R5: In both loopback modes (01, 11), the receiver samples the transmitter output on `tx_tick`. `rxd_pin`, `rx_tick`, `cts_pin` and `cd_pin` have no effect on what is received or sent.
- R6: In mode 01, `txd_pin` shows the transmitted frame. When `txd_hold_high` is 1 it is held at 1 instead.
- R7: In modes 10 and 11, `txd_pin` equals the value `rxd_pin` had at the most recent `rx_tick`, updated one clock after the strobe.
- R8: In mode 10, the receiver decodes `rxd_pin` on `rx_tick` and needs `cd_pin` high at the start bit. `cts_pin` is ignored, so `tx_ready` is high whenever the transmitter is idle.
- R9: In mode 11, loopback and echo run at the same time: the FIFO receives the transmitted character while `txd_pin` echoes `rxd_pin`.
- R10: `rts_pin` is 1 while a character is offered (`tx_valid`) or being sent, and is 0 otherwise. `rts_off`=1 forces it to 0 in every mode.
- R11: While `rx_en` is 0, the receive FIFO is emptied and `rx_out_valid` is 0 from the next clock on.
- R12: A character whose reception is cut short by `rx_en` going low is never written to the FIFO. The receiver then waits for a new start bit.
- R13: The FIFO holds FIFO_DEPTH characters in arrival order. `rx_out_data` is the oldest character while `rx_out_valid` is 1, and `rx_pop` removes it. A character that completes while the FIFO is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_req | input | 2 | Requested diagnostic mode |
| txd_hold_high | input | 1 | In local loopback, hold the transmit pin high |
| rts_off | input | 1 | Force the request-to-send pin inactive |
| rx_en | input | 1 | Receive enable; low flushes and idles the receiver |
| tx_tick | input | 1 | Transmit bit strobe |
| rx_tick | input | 1 | Receive bit strobe |
| tx_valid | input | 1 | Character offered for transmission |
| tx_data | input | DATA_W | Character to transmit |
| tx_ready | output | 1 | Transmitter accepts a character this cycle |
| rx_pop | input | 1 | Remove the oldest received character |
| rx_out_valid | output | 1 | Receive FIFO is not empty |
| rx_out_data | output | DATA_W | Oldest received character |
| txd_pin | output | 1 | Transmit data pin |
| rxd_pin | input | 1 | Receive data pin |
| rts_pin | output | 1 | Request-to-send, active high |
| cts_pin | input | 1 | Clear-to-send, active high |
| cd_pin | input | 1 | Carrier detect, active high |
| mode_now | output | 2 | Active diagnostic mode |

## Verification
The bench builds the block with DATA_W=8 and FIFO_DEPTH=4. With these values it can sweep all 256 character values through both local loopback and automatic echo, checking every frame bit on the pin. A depth of four lets a five-character burst reach the full-FIFO drop within a few hundred cycles. Normal mode, the combined mode, modem-line gating, a mode request made mid-frame, the flush, and an abort after four data bits are each driven with fixed characters whose frame bits the bench computes itself.

// File: rtl/diag_pkg.sv
package diag_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_LOOP   = 2'b01,
    MODE_ECHO   = 2'b10,
    MODE_BOTH   = 2'b11
  } diag_mode_e;

  // receiver is fed from the transmitter instead of the pin
  function automatic logic loops_back(diag_mode_e m);
    return m[0];
  endfunction

  // transmit pin carries the receive pin instead of the transmitter
  function automatic logic echoes(diag_mode_e m);
    return m[1];
  endfunction

  // clear-to-send only gates the transmitter in plain operation
  function automatic logic cts_honoured(diag_mode_e m);
    return m == MODE_NORMAL;
  endfunction

  // carrier detect gates the receiver whenever it listens to the pin
  function automatic logic cd_honoured(diag_mode_e m);
    return !m[0];
  endfunction

endpackage

// File: rtl/diag_tx_shift.sv
module diag_tx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              send_ok,
  input  logic              valid,
  input  logic [DATA_W-1:0] data,
  output logic              ready,
  output logic              line_bit,
  output logic              busy
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   left;
  logic               load;

  assign busy  = (left != '0);
  assign ready = !busy && send_ok;
  assign load  = valid && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg    <= '1;
      left     <= '0;
      line_bit <= 1'b1;
    end else if (load) begin
      shreg <= {1'b1, data, 1'b0};
      left  <= CNT_W'(FRAME_W);
    end else if (busy && tick) begin
      line_bit <= shreg[0];
      shreg    <= {1'b1, shreg[FRAME_W-1:1]};
      left     <= left - 1'b1;
    end
  end

endmodule

// File: rtl/diag_rx_shift.sv
module diag_rx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              tick,
  input  logic              line_bit,
  input  logic              start_ok,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              busy
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [CNT_W-1:0] got;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      got  <= '0;
      done <= 1'b0;
      data <= '0;
    end else if (!enable) begin
      busy <= 1'b0;
      got  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        if (!busy) begin
          if (!line_bit && start_ok) begin
            busy <= 1'b1;
            got  <= '0;
          end
        end else begin
          data <= {line_bit, data[DATA_W-1:1]};
          if (got == CNT_W'(DATA_W - 1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            got <= got + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/diag_rx_fifo.sv
module diag_rx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd,
  output logic [DATA_W-1:0] rd_data,
  output logic              not_empty,
  output logic              full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp, rp;
  logic [AW:0]       fill;
  logic              do_wr, do_rd;

  assign not_empty = (fill != '0);
  assign full      = (fill == (AW+1)'(DEPTH));
  assign do_wr     = wr && !full;
  assign do_rd     = rd && not_empty;
  assign rd_data   = mem[rp];

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_wr && !flush) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (do_wr) wp <= bump(wp);
      if (do_rd) rp <= bump(rp);
      fill <= fill + (do_wr ? 1'b1 : 1'b0) - (do_rd ? 1'b1 : 1'b0);
    end
  end

endmodule

// File: rtl/diag_router.sv
module diag_router
  import diag_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_req,
  input  logic              txd_hold_high,
  input  logic              rts_off,
  input  logic              rx_en,
  input  logic              tx_tick,
  input  logic              rx_tick,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  input  logic              rx_pop,
  output logic              rx_out_valid,
  output logic [DATA_W-1:0] rx_out_data,
  output logic              txd_pin,
  input  logic              rxd_pin,
  output logic              rts_pin,
  input  logic              cts_pin,
  input  logic              cd_pin,
  output logic [1:0]        mode_now
);

  diag_mode_e        mode_q;
  logic              tx_busy, rx_busy, tx_bit;
  logic              cts_ok, cd_ok, both_idle;
  logic              rx_src, rx_strobe;
  logic              echo_q;
  logic              fifo_wr, fifo_full;
  logic [DATA_W-1:0] fifo_wdata;

  // mode register: adopted only between characters
  assign both_idle = !tx_busy && !rx_busy;

  always_ff @(posedge clk) begin
    if (!rst_n)         mode_q <= MODE_NORMAL;
    else if (both_idle) mode_q <= diag_mode_e'(mode_req);
  end
  assign mode_now = mode_q;

  // modem line gating
  assign cts_ok  = !cts_honoured(mode_q) || cts_pin;
  assign cd_ok   = !cd_honoured(mode_q) || cd_pin;
  assign rts_pin = !rts_off && (tx_valid || tx_busy);

  // receiver source and strobe: one shared strobe in loopback
  assign rx_src    = loops_back(mode_q) ? tx_bit  : rxd_pin;
  assign rx_strobe = loops_back(mode_q) ? tx_tick : rx_tick;

  // echo retimer, driven by the receive strobe
  always_ff @(posedge clk) begin
    if (!rst_n)       echo_q <= 1'b1;
    else if (rx_tick) echo_q <= rxd_pin;
  end

  always_comb begin
    if (echoes(mode_q))                           txd_pin = echo_q;
    else if (mode_q == MODE_LOOP && txd_hold_high) txd_pin = 1'b1;
    else                                          txd_pin = tx_bit;
  end

  diag_tx_shift #(.DATA_W(DATA_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tx_tick),
    .send_ok  (cts_ok),
    .valid    (tx_valid),
    .data     (tx_data),
    .ready    (tx_ready),
    .line_bit (tx_bit),
    .busy     (tx_busy)
  );

  diag_rx_shift #(.DATA_W(DATA_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (rx_en),
    .tick     (rx_strobe),
    .line_bit (rx_src),
    .start_ok (cd_ok),
    .done     (fifo_wr),
    .data     (fifo_wdata),
    .busy     (rx_busy)
  );

  diag_rx_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (!rx_en),
    .wr        (fifo_wr),
    .wr_data   (fifo_wdata),
    .rd        (rx_pop),
    .rd_data   (rx_out_data),
    .not_empty (rx_out_valid),
    .full      (fifo_full)
  );

endmodule

// File: rtl/diag_router_chk.sv
module diag_router_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_now,
  input logic       txd_hold_high,
  input logic       rts_off,
  input logic       rx_en,
  input logic       rx_tick,
  input logic       tx_ready,
  input logic       rx_out_valid,
  input logic       txd_pin,
  input logic       rxd_pin,
  input logic       rts_pin,
  input logic       cts_pin,
  input logic       tx_busy,
  input logic       rx_busy,
  input logic       fifo_wr
);

  // R2: no mode switch while a character is in flight
  a_r2_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy || rx_busy) |=> (mode_now == $past(mode_now)));

  // R4: transmitter refuses characters without clear-to-send in normal mode
  a_r4_cts_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_now == 2'b00 && !cts_pin) |-> !tx_ready);

  // R6: loopback with hold keeps the pin high
  a_r6_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_now == 2'b01 && txd_hold_high) |-> txd_pin);

  // R7: echo output follows the pin sampled at the receive strobe
  a_r7_echo_follow: assert property (@(posedge clk) disable iff (!rst_n)
    rx_tick |=> (!mode_now[1] || txd_pin == $past(rxd_pin)));

  // R10: request-to-send forced off
  a_r10_rts_off: assert property (@(posedge clk) disable iff (!rst_n)
    rts_off |-> !rts_pin);

  // R11: disabled receiver leaves the FIFO empty
  a_r11_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_out_valid);

  // R12: no character completes while the receiver is disabled
  a_r12_no_write_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!fifo_wr && !rx_busy));

endmodule

bind diag_router diag_router_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mode_now      (mode_now),
  .txd_hold_high (txd_hold_high),
  .rts_off       (rts_off),
  .rx_en         (rx_en),
  .rx_tick       (rx_tick),
  .tx_ready      (tx_ready),
  .rx_out_valid  (rx_out_valid),
  .txd_pin       (txd_pin),
  .rxd_pin       (rxd_pin),
  .rts_pin       (rts_pin),
  .cts_pin       (cts_pin),
  .tx_busy       (tx_busy),
  .rx_busy       (rx_busy),
  .fifo_wr       (fifo_wr)
);

// File: tb/diag_router_test.sv
`timescale 1ns/1ps
module diag_router_test;
  localparam int W = 8;
  localparam int D = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   mode_req = 2'b00;
  logic         txd_hold_high = 1'b0, rts_off = 1'b0, rx_en = 1'b1;
  logic         tx_tick = 1'b0, rx_tick = 1'b0, tx_valid = 1'b0;
  logic [W-1:0] tx_data = '0;
  logic         tx_ready, rx_pop = 1'b0, rx_out_valid;
  logic [W-1:0] rx_out_data;
  logic         txd_pin, rxd_pin = 1'b1, rts_pin;
  logic         cts_pin = 1'b1, cd_pin = 1'b1;
  logic [1:0]   mode_now;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  diag_router #(.DATA_W(W), .FIFO_DEPTH(D)) uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  // frame bit i of character d: start, LSB-first data, stop
  function automatic bit frame_bit(input logic [W-1:0] d, input int i);
    if (i == 0) return 1'b0;
    if (i <= W) return d[i-1];
    return 1'b1;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit t, input bit r);
    tx_tick = t; rx_tick = r;
    @(negedge clk);
    tx_tick = 1'b0; rx_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_mode(input logic [1:0] m);
    mode_req = m;
    cyc(2);
    eq("R1 mode adopted", mode_now, m);
  endtask

  task automatic offer(input logic [W-1:0] d);
    int guard = 0;
    tx_valid = 1'b1; tx_data = d;
    while (!tx_ready && guard < 50) begin @(negedge clk); guard++; end
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic pop_expect(input string req, input logic [W-1:0] d);
    eq({req, " valid"}, rx_out_valid, 1);
    eq({req, " data"}, rx_out_data, d);
    rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
  endtask

  // transmit a character with tx strobes, checking the pin per bit
  task automatic send_check(input logic [W-1:0] d, input bit hold, input string req);
    offer(d);
    for (int i = 0; i < W + 2; i++) begin
      pulse(1'b1, 1'b0);
      eq(req, txd_pin, hold ? 1 : frame_bit(d, i));
    end
    cyc(2);
  endtask

  // drive a frame on the receive pin; optional tx strobes and echo check
  task automatic rx_frame(input logic [W-1:0] d, input bit with_tx, input bit echo_chk);
    for (int i = 0; i < W + 2; i++) begin
      rxd_pin = frame_bit(d, i);
      pulse(with_tx, 1'b1);
      if (echo_chk) eq("R7 echo bit", txd_pin, frame_bit(d, i));
    end
    rxd_pin = 1'b1;
    cyc(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R1, R10, R13)
    eq("R1 reset mode", mode_now, 0);
    eq("R3 reset line high", txd_pin, 1);
    eq("R10 reset rts", rts_pin, 0);
    eq("R13 reset empty", rx_out_valid, 0);

    // normal mode: CTS gating, RTS, frame on pin
    cts_pin = 1'b0; tx_valid = 1'b1; tx_data = 8'hA5;
    cyc(3);
    eq("R4 no cts not ready", tx_ready, 0);
    eq("R4 no cts line idle", txd_pin, 1);
    eq("R10 rts while offered", rts_pin, 1);
    rts_off = 1'b1; @(negedge clk);
    eq("R10 rts forced off", rts_pin, 0);
    rts_off = 1'b0;
    cts_pin = 1'b1; @(negedge clk); tx_valid = 1'b0;
    eq("R10 rts while sending", rts_pin, 1);
    for (int i = 0; i < W + 2; i++) begin
      pulse(1'b1, 1'b0);
      eq("R3 normal frame bit", txd_pin, frame_bit(8'hA5, i));
    end
    cyc(1);
    eq("R10 rts idle after frame", rts_pin, 0);

    // normal receive: CD gating, no echo on pin
    cd_pin = 1'b0;
    rx_frame(8'h5A, 1'b0, 1'b0);
    eq("R4 no cd nothing received", rx_out_valid, 0);
    cd_pin = 1'b1;
    rx_frame(8'h5A, 1'b0, 1'b0);
    eq("R3 normal no echo", txd_pin, 1);
    pop_expect("R4 cd received", 8'h5A);

    // local loopback sweep, modem lines deasserted (R5, R6)
    set_mode(2'b01);
    cts_pin = 1'b0; cd_pin = 1'b0;
    for (int d = 0; d < 256; d++) begin
      send_check(W'(d), 1'b0, "R6 loop pin shows frame");
      pop_expect("R5 loopback char", W'(d));
    end
    txd_hold_high = 1'b1;
    send_check(8'h81, 1'b1, "R6 loop pin held high");
    pop_expect("R5 loopback char under hold", 8'h81);
    txd_hold_high = 1'b0;
    // receive pin and strobe ignored in loopback
    rxd_pin = 1'b0;
    for (int i = 0; i < W + 3; i++) pulse(1'b0, 1'b1);
    rxd_pin = 1'b1; cyc(2);
    eq("R5 rx pin ignored", rx_out_valid, 0);
    eq("R5 no echo in loopback", txd_pin, 1);

    // FIFO depth and drop when full (R13)
    for (int k = 0; k < D + 1; k++) send_check(W'(8'h10 + k), 1'b0, "R6 loop pin burst");
    for (int k = 0; k < D; k++) pop_expect("R13 fifo order", W'(8'h10 + k));
    eq("R13 fifth dropped", rx_out_valid, 0);

    // flush (R11)
    send_check(8'h33, 1'b0, "R6 loop pin pre-flush");
    send_check(8'h44, 1'b0, "R6 loop pin pre-flush");
    eq("R11 fifo filled", rx_out_valid, 1);
    rx_en = 1'b0; @(negedge clk);
    eq("R11 flushed", rx_out_valid, 0);
    rx_en = 1'b1; cyc(1);
    eq("R11 stays empty", rx_out_valid, 0);

    // mode request during a frame (R2)
    offer(8'hC3);
    for (int i = 0; i < 3; i++) pulse(1'b1, 1'b0);
    mode_req = 2'b00; cyc(2);
    eq("R2 mode held mid-frame", mode_now, 1);
    for (int i = 3; i < W + 2; i++) pulse(1'b1, 1'b0);
    cyc(2);
    eq("R2 mode adopted when idle", mode_now, 0);
    pop_expect("R2 char intact", 8'hC3);
    cts_pin = 1'b1; cd_pin = 1'b1;

    // abort mid-character (R12): 0xF0 sends four zeros then ones
    for (int i = 0; i < 5; i++) begin
      rxd_pin = frame_bit(8'hF0, i); pulse(1'b0, 1'b1);
    end
    rx_en = 1'b0; @(negedge clk); rx_en = 1'b1;
    for (int i = 5; i < W + 2; i++) begin
      rxd_pin = frame_bit(8'hF0, i); pulse(1'b0, 1'b1);
    end
    rxd_pin = 1'b1; cyc(3);
    eq("R12 aborted char absent", rx_out_valid, 0);
    rx_frame(8'h3C, 1'b0, 1'b0);
    pop_expect("R12 next char received", 8'h3C);

    // automatic echo sweep (R7, R8)
    set_mode(2'b10);
    cts_pin = 1'b0;
    @(negedge clk);
    eq("R8 cts ignored in echo", tx_ready, 1);
    for (int d = 0; d < 256; d++) begin
      rx_frame(W'(d), 1'b0, 1'b1);
      pop_expect("R8 echo receive", W'(d));
    end
    cd_pin = 1'b0;
    rx_frame(8'h96, 1'b0, 1'b1);
    eq("R8 no cd in echo", rx_out_valid, 0);

    // loopback plus echo (R9)
    set_mode(2'b11);
    offer(8'h6E);
    eq("R9 cts ignored", tx_ready, 0);
    rx_frame(8'hB1, 1'b1, 1'b1);
    pop_expect("R9 loopback char with cd low", 8'h6E);
    eq("R9 pin char not received", rx_out_valid, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule